// File: doc/BRIEF.md
# Sigma-Delta Automatic Gain Control Loop

This block closes a gain loop around the tuner ahead of the ADCs without needing carrier or symbol-timing lock. It uses only the size of each incoming sample. For every accepted I/Q sample pair, it forms a magnitude estimate. The estimate comes from the I sample, from the Q sample, or from the mean of both magnitudes. The block subtracts this estimate from a programmed target level, scales the difference with an arithmetic right shift, and adds the result to a saturating gain integrator.

A first-order sigma-delta modulator runs on every clock. It turns the upper bits of the gain word into a one-bit pulse stream. An external RC low-pass filter converts this stream into the analog gain-control voltage for the tuner. A polarity control suits tuners whose gain falls as the voltage rises. A freeze input holds the integrator. Reset loads a programmed starting gain.

The sample input is a valid/ready stream that never applies back-pressure. `smp_ready` is high in every cycle, so a sample is consumed on each rising clock edge at which `smp_valid` is high. The modulator output and the gain word change regardless of the stream.

Top module: `agc_sd_loop`

## Requirements
- R1: Samples are 8-bit two's complement. With `cfg_src` = 0 the level is the magnitude of `smp_i`; with `cfg_src` = 1 it is the magnitude of `smp_q`. The magnitude of -128 is 128.
- R2: With `cfg_src` = 2 or 3 the level is (|I| + |Q|) shifted right by one, which rounds down.
- R3: On each accepted sample with `freeze` low, the gain word changes by (`cfg_target` − level) arithmetically shifted right by `cfg_shift`. The shift rounds toward minus infinity, so −3 shifted by 2 gives −1. The new value is visible after that clock edge.
- R4: The gain word saturates at 0 and at 65535 instead of wrapping.
- R5: While `rst_n` is low at a clock edge, the gain word is loaded with `cfg_init_gain` and the modulator accumulator is cleared.
- R6: When `freeze` is high, or no sample is accepted, the gain word keeps its value.
- R7: `smp_ready` is high in every cycle. Consecutive valid cycles each add their own step.
- R8: With the gain word constant, `pdm_out` (with `cfg_invert` = 0) is high in exactly G of any 256 consecutive cycles. G is bits 15:8 of the gain word.
- R9: With `cfg_invert` = 1, `pdm_out` is the complement of the non-inverted stream. Over 256 cycles it is therefore high 256 − G times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample pair present |
| smp_ready | output | 1 | Always high; no back-pressure |
| smp_i | input | 8 | I sample, two's complement |
| smp_q | input | 8 | Q sample, two's complement |
| cfg_src | input | 2 | Detector source: 0 I, 1 Q, 2/3 average |
| cfg_target | input | 8 | Target level, unsigned |
| cfg_shift | input | 3 | Error right-shift amount |
| cfg_init_gain | input | 16 | Gain loaded during reset |
| cfg_invert | input | 1 | Invert output polarity |
| freeze | input | 1 | Hold the gain integrator |
| gain_word | output | 16 | Current integrator value |
| pdm_out | output | 1 | One-bit sigma-delta stream |

## Verification
The integrator is driven one sample at a time from a known starting gain. The patterns are chosen to separate several behaviours:
- positive and negative samples of equal size, which separates a true magnitude from a raw value;
- I-only, Q-only and mixed-sign averaged pairs, which show that the source selection picks the right channel;
- a negative error shifted by a non-zero amount, which exposes a logical shift used in place of an arithmetic one;
- starting values near both ends, which show whether the integrator wraps instead of saturating.

The output stream is counted over full 256-cycle windows at a fixed gain in both polarities. This confirms that the pulse density follows the top byte of the gain word.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    SRC_I    = 2'd0,
    SRC_Q    = 2'd1,
    SRC_AVG  = 2'd2,
    SRC_AVG2 = 2'd3
  } agc_src_e;
endpackage

// File: rtl/agc_level_det.sv
module agc_level_det #(
  parameter int SW = 8
) (
  input  logic [SW-1:0] i_s,
  input  logic [SW-1:0] q_s,
  input  logic [1:0]    src,
  output logic [SW-1:0] lvl
);
  import agc_pkg::*;

  logic [SW-1:0] raw [2];
  logic [SW-1:0] mag [2];
  logic [SW:0]   mag_sum;

  assign raw[0] = i_s;
  assign raw[1] = q_s;

  for (genvar ch = 0; ch < 2; ch++) begin : g_mag
    // two's complement magnitude; the most negative code maps to 2^(SW-1)
    assign mag[ch] = raw[ch][SW-1] ? (~raw[ch] + 1'b1) : raw[ch];
  end

  assign mag_sum = {1'b0, mag[0]} + {1'b0, mag[1]};

  always_comb begin
    unique case (agc_src_e'(src))
      SRC_I:   lvl = mag[0];
      SRC_Q:   lvl = mag[1];
      default: lvl = mag_sum[SW:1];
    endcase
  end
endmodule

// File: rtl/agc_integrator.sv
module agc_integrator #(
  parameter int SW  = 8,
  parameter int GW  = 16,
  parameter int SHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_en,
  input  logic [SW-1:0]  target,
  input  logic [SW-1:0]  lvl,
  input  logic [SHW-1:0] shift,
  input  logic [GW-1:0]  init_gain,
  output logic [GW-1:0]  gain
);
  localparam int EW = SW + 2;
  localparam int XW = GW + 2;

  logic signed [EW-1:0] err;
  logic signed [EW-1:0] err_sh;
  logic signed [XW-1:0] err_ext;
  logic signed [XW-1:0] sum;
  logic [GW-1:0]        nxt;

  assign err     = $signed({2'b00, target}) - $signed({2'b00, lvl});
  assign err_sh  = err >>> shift;
  assign err_ext = {{(XW-EW){err_sh[EW-1]}}, err_sh};
  assign sum     = $signed({2'b00, gain}) + err_ext;

  always_comb begin
    if (sum[XW-1])     nxt = '0;
    else if (sum[GW])  nxt = '1;
    else               nxt = sum[GW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        gain <= init_gain;
    else if (step_en)  gain <= nxt;
  end
endmodule

// File: rtl/agc_sdm.sv
module agc_sdm #(
  parameter int GW = 16,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] gain,
  input  logic          invert,
  output logic          bit_out
);
  logic [MW-1:0] acc;
  logic          carry_q;
  logic [MW:0]   acc_sum;

  assign acc_sum = {1'b0, acc} + {1'b0, gain[GW-1 -: MW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      carry_q <= 1'b0;
    end else begin
      acc     <= acc_sum[MW-1:0];
      carry_q <= acc_sum[MW];
    end
  end

  assign bit_out = carry_q ^ invert;
endmodule

// File: rtl/agc_sd_loop.sv
module agc_sd_loop #(
  parameter int SW  = 8,
  parameter int GW  = 16,
  parameter int SHW = 3,
  parameter int MW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_valid,
  output logic           smp_ready,
  input  logic [SW-1:0]  smp_i,
  input  logic [SW-1:0]  smp_q,
  input  logic [1:0]     cfg_src,
  input  logic [SW-1:0]  cfg_target,
  input  logic [SHW-1:0] cfg_shift,
  input  logic [GW-1:0]  cfg_init_gain,
  input  logic           cfg_invert,
  input  logic           freeze,
  output logic [GW-1:0]  gain_word,
  output logic           pdm_out
);
  logic [SW-1:0] lvl;
  logic          take;

  assign smp_ready = 1'b1;
  assign take      = smp_valid && smp_ready && !freeze;

  agc_level_det #(.SW(SW)) u_det (
    .i_s (smp_i),
    .q_s (smp_q),
    .src (cfg_src),
    .lvl (lvl)
  );

  agc_integrator #(.SW(SW), .GW(GW), .SHW(SHW)) u_int (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (take),
    .target    (cfg_target),
    .lvl       (lvl),
    .shift     (cfg_shift),
    .init_gain (cfg_init_gain),
    .gain      (gain_word)
  );

  agc_sdm #(.GW(GW), .MW(MW)) u_sdm (
    .clk     (clk),
    .rst_n   (rst_n),
    .gain    (gain_word),
    .invert  (cfg_invert),
    .bit_out (pdm_out)
  );
endmodule

// File: rtl/agc_sd_loop_chk.sv
module agc_sd_loop_chk #(
  parameter int SW = 8,
  parameter int GW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          freeze,
  input logic [SW-1:0] cfg_target,
  input logic [GW-1:0] cfg_init_gain,
  input logic [SW-1:0] lvl,
  input logic [GW-1:0] gain_word
);
  // R6: no accepted sample or frozen -> gain held
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid || freeze) |=> $stable(gain_word));

  // R3: level below target never lowers the gain
  a_r3_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !freeze && lvl < cfg_target) |=> gain_word >= $past(gain_word));

  // R3: level above target never raises the gain
  a_r3_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !freeze && lvl > cfg_target) |=> gain_word <= $past(gain_word));

  // R5: reset loads the programmed starting gain
  a_r5_init: assert property (@(posedge clk)
    (!rst_n) |=> gain_word == $past(cfg_init_gain));
endmodule

bind agc_sd_loop agc_sd_loop_chk #(.SW(SW), .GW(GW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .smp_valid     (smp_valid),
  .freeze        (freeze),
  .cfg_target    (cfg_target),
  .cfg_init_gain (cfg_init_gain),
  .lvl           (lvl),
  .gain_word     (gain_word)
);

// File: tb/agc_sd_loop_test.sv
module agc_sd_loop_test;
  localparam int PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [7:0]  smp_i = '0, smp_q = '0;
  logic [1:0]  cfg_src = '0;
  logic [7:0]  cfg_target = '0;
  logic [2:0]  cfg_shift = '0;
  logic [15:0] cfg_init_gain = 16'h8000;
  logic        cfg_invert = 1'b0;
  logic        freeze = 1'b0;
  logic [15:0] gain_word;
  logic        pdm_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  agc_sd_loop uut (.*);

  // src, i, q, target, shift, init, expected gain
  localparam logic [60:0] VEC [NV] = '{
    {2'd0, 8'd50,  8'd0,   8'd100, 3'd0, 16'd32768, 16'd32818}, // R1 positive I
    {2'd0, 8'hCE,  8'd0,   8'd100, 3'd0, 16'd32768, 16'd32818}, // R1 negative I
    {2'd1, 8'd100, 8'hEC,  8'd30,  3'd0, 16'd32768, 16'd32778}, // R1 Q selected
    {2'd2, 8'h9C,  8'h3C,  8'd20,  3'd0, 16'd32768, 16'd32708}, // R2 average
    {2'd2, 8'd127, 8'h80,  8'd0,   3'd0, 16'd32768, 16'd32641}, // R2 floor of 255/2
    {2'd0, 8'h80,  8'd0,   8'd0,   3'd3, 16'd32768, 16'd32752}, // R3 shift of -128
    {2'd0, 8'd3,   8'd0,   8'd0,   3'd2, 16'd32768, 16'd32767}, // R3 floor of -3>>>2
    {2'd0, 8'd0,   8'd0,   8'd120, 3'd0, 16'd65520, 16'd65535}, // R4 upper clamp
    {2'd0, 8'h80,  8'd0,   8'd0,   3'd0, 16'd16,    16'd0},     // R4 lower clamp
    {2'd3, 8'd10,  8'd30,  8'd40,  3'd0, 16'd32768, 16'd32788}  // R2 code 3 averages
  };

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic do_reset(input logic [15:0] g);
    @(negedge clk);
    cfg_init_gain = g;
    rst_n = 1'b0;
    smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic one_sample(input logic [7:0] i, input logic [7:0] q);
    smp_i = i;
    smp_q = q;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic count_ones(output int ones);
    ones = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (pdm_out) ones++;
    end
  endtask

  initial begin
    int ones;
    logic [15:0] g0;
    freeze = 1'b0;
    do_reset(16'h8000);
    check("R5 reset gain", gain_word, 16'h8000);
    check("R7 ready", smp_ready, 1);

    for (int v = 0; v < NV; v++) begin
      cfg_src    = VEC[v][60:59];
      cfg_target = VEC[v][42:35];
      cfg_shift  = VEC[v][34:32];
      do_reset(VEC[v][31:16]);
      one_sample(VEC[v][58:51], VEC[v][50:43]);
      check($sformatf("R1-R4 vector %0d", v), gain_word, VEC[v][15:0]);
    end

    // R7: two back-to-back samples both counted
    cfg_src = 2'd0; cfg_target = 8'd40; cfg_shift = 3'd0;
    do_reset(16'h8000);
    smp_i = 8'd30; smp_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    check("R7 back-to-back", gain_word, 32788);

    // R6: freeze blocks an accepted sample
    g0 = gain_word;
    freeze = 1'b1;
    one_sample(8'h80, 8'h80);
    @(negedge clk);
    check("R6 freeze", gain_word, g0);
    freeze = 1'b0;

    // R6: idle cycles keep the gain
    smp_i = 8'h80;
    repeat (5) @(negedge clk);
    check("R6 idle", gain_word, g0);

    // R8: density equals top byte
    freeze = 1'b1;
    cfg_invert = 1'b0;
    do_reset(16'h4000);
    repeat (3) @(negedge clk);
    count_ones(ones);
    check("R8 density 64", ones, 64);
    do_reset(16'hC35A);
    count_ones(ones);
    check("R8 density 195", ones, 195);

    // R9: inverted polarity
    cfg_invert = 1'b1;
    count_ones(ones);
    check("R9 inverted density", ones, 256 - 195);
    cfg_invert = 1'b0;
    freeze = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule